// File: doc/BRIEF.md
# Flash Read Buffer Address Tracker

This block follows the byte addresses that a host reads from an emulated serial flash and decides, for every byte, where its data should come from. A read lands in a small mailbox window when that window is enabled and the address falls inside it. Otherwise, in emulation mode, the data comes from a read buffer split into two equal halves. In passthrough mode it comes from the downstream flash, or is driven as high impedance when the command has been blocked. The decision is made one byte at a time, so a single read can move into or out of the mailbox partway through and change its source there.

For software that refills the two buffer halves in turn, the block raises a one-cycle flip pulse whenever reading moves into the other half. This includes the wrap from the top of the buffer back to index 0. It also raises a one-cycle watermark pulse when the offset within the current half reaches a programmed threshold. The address of the final byte of each transaction is kept so software can read it after chip select is released.

Top module: `flash_rdbuf_tracker`

## Requirements
- R1: While `mbx_en_i` is 1, a byte whose address matches `mbx_base_i` on every bit above bit MBX_W-1 is reported with `src_o` = 1 (mailbox). A read that enters or leaves the window changes source at the first byte on the other side.
- R2: While `mbx_en_i` is 0, no byte is reported with `src_o` = 1.
- R3: With `pass_mode_i` = 0, every byte outside the mailbox is reported with `src_o` = 0 (read buffer).
- R4: With `pass_mode_i` = 1, every byte outside the mailbox is reported with `src_o` = 3 (high impedance) if `filtered_i` = 1, and with `src_o` = 2 (downstream) otherwise.
- R5: The buffer half of a byte is address bit HALF_W, and it starts at 0 after reset. `flip_o` is high for exactly the one cycle after a read-buffer byte whose half differs from that of the previous read-buffer byte. Because the address above bit HALF_W is ignored, reading past the buffer end wraps to half 0.
- R6: `wmark_o` is high for the one cycle after a read-buffer byte whose offset (address bits HALF_W-1:0) is at least `wmark_thr_i`. It fires at most once per half: it is re-armed only by a flip, and the byte that flips may itself fire it.
- R7: When `csb_i` rises, `last_addr_o` takes the address of the last byte accepted while `csb_i` was 0, one cycle later. Transactions without bytes, and bytes presented while `csb_i` is 1, leave it unchanged.
- R8: After reset, `flip_o` and `wmark_o` are 0 and `last_addr_o` is 0.
- R9: Mailbox and passthrough bytes raise no events and do not change the tracked buffer half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb_i | input | 1 | Chip select, active low |
| byte_vld_i | input | 1 | A read byte address is presented this cycle |
| byte_addr_i | input | ADDR_W | Byte address being read |
| pass_mode_i | input | 1 | 1 = passthrough mode, 0 = emulation mode |
| filtered_i | input | 1 | Current command is blocked from the downstream flash |
| mbx_en_i | input | 1 | Mailbox window enable |
| mbx_base_i | input | ADDR_W | Mailbox base address, aligned to 2**MBX_W |
| wmark_thr_i | input | HALF_W | Watermark threshold within a half |
| src_o | output | 2 | Data source: 0 buffer, 1 mailbox, 2 downstream, 3 high-Z |
| flip_o | output | 1 | One-cycle pulse on a buffer half change |
| wmark_o | output | 1 | One-cycle pulse when the watermark is reached |
| last_addr_o | output | ADDR_W | Address of the final byte of the last transaction |

## Verification
The hardest state to reach from the ports is a watermark that has already fired being re-armed by a flip, with mailbox bytes interleaved so that they must leave the tracked half untouched. The stimulus makes long sequential reads that cross both halves and wrap past the buffer end. It then places reads that enter and leave the mailbox in the middle of a half, and finishes with a zero threshold so that the flip and the watermark land on the same byte. A reference model in the driver predicts source, flip and watermark for every byte.

// File: rtl/rdbuf_trk_pkg.sv
package rdbuf_trk_pkg;
  typedef enum logic [1:0] {
    SRC_RDBUF = 2'd0,
    SRC_MBX   = 2'd1,
    SRC_DOWN  = 2'd2,
    SRC_HIZ   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/rdbuf_mbx_decode.sv
module rdbuf_mbx_decode #(
  parameter int ADDR_W = 24,
  parameter int MBX_W  = 5
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - MBX_W;

  logic [TAG_W-1:0] addr_tag;
  logic [TAG_W-1:0] base_tag;

  assign addr_tag = addr_i[ADDR_W-1:MBX_W];
  assign base_tag = base_i[ADDR_W-1:MBX_W];
  assign hit_o    = en_i && (addr_tag == base_tag);
endmodule

// File: rtl/rdbuf_evt_gen.sv
module rdbuf_evt_gen #(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_byte_i,
  input  logic              half_i,
  input  logic [HALF_W-1:0] off_i,
  input  logic [HALF_W-1:0] thr_i,
  output logic              flip_o,
  output logic              wmark_o
);
  logic half_q, half_d;
  logic armed_q, armed_d;
  logic flip_now, arm_eff, wm_now;
  logic flip_q, wm_q;

  always_comb begin
    flip_now = rb_byte_i && (half_i != half_q);
    arm_eff  = armed_q || flip_now;
    wm_now   = rb_byte_i && arm_eff && (off_i >= thr_i);
    half_d   = half_q;
    armed_d  = armed_q;
    if (rb_byte_i) begin
      half_d = half_i;
      if (wm_now)        armed_d = 1'b0;
      else if (flip_now) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (rb_byte_i) begin
      half_q  <= half_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q <= 1'b0;
      wm_q   <= 1'b0;
    end else begin
      flip_q <= flip_now;
      wm_q   <= wm_now;
    end
  end

  assign flip_o  = flip_q;
  assign wmark_o = wm_q;
endmodule

// File: rtl/rdbuf_last_addr.sv
module rdbuf_last_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] last_o
);
  logic              csb_q;
  logic              seen_q, seen_d;
  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] last_q;
  logic              csb_rise;
  logic              commit;

  always_comb begin
    csb_rise = csb_i && !csb_q;
    commit   = csb_rise && seen_q;
    seen_d   = seen_q;
    if (take_i)      seen_d = 1'b1;
    else if (commit) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csb_q  <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      csb_q  <= csb_i;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (take_i) pend_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (commit) last_q <= pend_q;
  end

  assign last_o = last_q;
endmodule

// File: rtl/flash_rdbuf_tracker.sv
module flash_rdbuf_tracker
  import rdbuf_trk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 6,
  parameter int MBX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_i,
  input  logic              byte_vld_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic              pass_mode_i,
  input  logic              filtered_i,
  input  logic              mbx_en_i,
  input  logic [ADDR_W-1:0] mbx_base_i,
  input  logic [HALF_W-1:0] wmark_thr_i,
  output logic [1:0]        src_o,
  output logic              flip_o,
  output logic              wmark_o,
  output logic [ADDR_W-1:0] last_addr_o
);
  logic    mbx_hit;
  logic    take;
  logic    rb_byte;
  rd_src_e src;

  rdbuf_mbx_decode #(.ADDR_W(ADDR_W), .MBX_W(MBX_W)) u_mbx (
    .en_i   (mbx_en_i),
    .addr_i (byte_addr_i),
    .base_i (mbx_base_i),
    .hit_o  (mbx_hit)
  );

  always_comb begin
    if (mbx_hit)          src = SRC_MBX;
    else if (!pass_mode_i) src = SRC_RDBUF;
    else if (filtered_i)  src = SRC_HIZ;
    else                  src = SRC_DOWN;
  end

  assign take    = byte_vld_i && !csb_i;
  assign rb_byte = take && (src == SRC_RDBUF);
  assign src_o   = src;

  rdbuf_evt_gen #(.HALF_W(HALF_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_byte_i (rb_byte),
    .half_i    (byte_addr_i[HALF_W]),
    .off_i     (byte_addr_i[HALF_W-1:0]),
    .thr_i     (wmark_thr_i),
    .flip_o    (flip_o),
    .wmark_o   (wmark_o)
  );

  rdbuf_last_addr #(.ADDR_W(ADDR_W)) u_last (
    .clk    (clk),
    .rst_n  (rst_n),
    .csb_i  (csb_i),
    .take_i (take),
    .addr_i (byte_addr_i),
    .last_o (last_addr_o)
  );
endmodule

// File: rtl/rdbuf_trk_chk.sv
module rdbuf_trk_chk #(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csb_i,
  input logic              byte_vld_i,
  input logic [ADDR_W-1:0] byte_addr_i,
  input logic              pass_mode_i,
  input logic              filtered_i,
  input logic              mbx_en_i,
  input logic [HALF_W-1:0] wmark_thr_i,
  input logic [1:0]        src_o,
  input logic              flip_o,
  input logic              wmark_o,
  input logic [ADDR_W-1:0] last_addr_o
);
  // R5
  flip_after_rdbuf_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_o |-> $past(byte_vld_i && !csb_i && src_o == 2'd0));

  // R6
  wmark_after_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wmark_o |-> $past(byte_vld_i && !csb_i && src_o == 2'd0 &&
                      byte_addr_i[HALF_W-1:0] >= wmark_thr_i));

  // R7
  last_addr_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_addr_o) |-> $past(csb_i));

  // R2
  no_mbx_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mbx_en_i |-> src_o != 2'd1);

  // R4
  hiz_only_filtered_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_o == 2'd3 |-> pass_mode_i && filtered_i);
endmodule

bind flash_rdbuf_tracker rdbuf_trk_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csb_i       (csb_i),
  .byte_vld_i  (byte_vld_i),
  .byte_addr_i (byte_addr_i),
  .pass_mode_i (pass_mode_i),
  .filtered_i  (filtered_i),
  .mbx_en_i    (mbx_en_i),
  .wmark_thr_i (wmark_thr_i),
  .src_o       (src_o),
  .flip_o      (flip_o),
  .wmark_o     (wmark_o),
  .last_addr_o (last_addr_o)
);

// File: tb/flash_rdbuf_tracker_tb.sv
module flash_rdbuf_tracker_tb;
  localparam int AW = 24;
  localparam int HW = 6;
  localparam int MW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          csb;
  logic          bvld;
  logic [AW-1:0] baddr;
  logic          pmode;
  logic          filt;
  logic          men;
  logic [AW-1:0] mbase;
  logic [HW-1:0] thr;
  logic [1:0]    src;
  logic          flip;
  logic          wm;
  logic [AW-1:0] last;

  int total = 0;
  int bad   = 0;

  // model state
  logic       m_half  = 1'b0;
  logic       m_armed = 1'b1;
  logic [3:0] expq[$];

  always #10 clk = ~clk;

  flash_rdbuf_tracker #(.ADDR_W(AW), .HALF_W(HW), .MBX_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .csb_i(csb), .byte_vld_i(bvld),
    .byte_addr_i(baddr), .pass_mode_i(pmode), .filtered_i(filt),
    .mbx_en_i(men), .mbx_base_i(mbase), .wmark_thr_i(thr),
    .src_o(src), .flip_o(flip), .wmark_o(wm), .last_addr_o(last)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one accepted byte, expected item pushed to the scoreboard
  task automatic rd(input logic [AW-1:0] a);
    logic [1:0] es;
    logic ef, ew, arm;
    @(negedge clk);
    bvld  = 1'b1;
    baddr = a;
    if (men && (a >> MW) == (mbase >> MW)) es = 2'd1;
    else if (!pmode) es = 2'd0;
    else if (filt)   es = 2'd3;
    else             es = 2'd2;
    ef = 1'b0;
    ew = 1'b0;
    if (es == 2'd0) begin
      ef  = (a[HW] != m_half);
      arm = m_armed || ef;
      ew  = arm && (a[HW-1:0] >= thr);
      m_half = a[HW];
      if (ew)      m_armed = 1'b0;
      else if (ef) m_armed = 1'b1;
    end
    expq.push_back({es, ef, ew});
  endtask

  task automatic rd_range(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    for (logic [AW-1:0] a = lo; a <= hi; a++) rd(a);
  endtask

  task automatic open_cs;
    @(negedge clk);
    bvld = 1'b0;
    csb  = 1'b0;
  endtask

  task automatic close_cs;
    @(negedge clk);
    bvld = 1'b0;
    csb  = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items as bytes are accepted
  always @(posedge clk) begin
    if (rst_n && bvld && !csb) begin
      #5;
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty actual=1 expected=0");
      end else begin
        logic [3:0] e;
        e = expq.pop_front();
        check("R1/R3/R4 src", AW'(src), AW'(e[3:2]));
        check("R5 flip", AW'(flip), AW'(e[1]));
        check("R6 wmark", AW'(wm), AW'(e[0]));
      end
    end
  end

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csb = 1'b1; bvld = 1'b0; baddr = '0;
    pmode = 1'b0; filt = 1'b0; men = 1'b0; mbase = '0; thr = 6'd16;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 flip", AW'(flip), '0);
    check("R8 wmark", AW'(wm), '0);
    check("R8 last", last, '0);
    rst_n = 1'b1;

    // R3 R5 R6: long read through both halves and wrap past the end
    open_cs;
    rd_range(24'h000, 24'h08F);
    close_cs;
    check("R7 last", last, 24'h08F);

    // R1 R9: read crosses into the mailbox and back out
    men = 1'b1; mbase = 24'h0A0;
    open_cs;
    rd_range(24'h098, 24'h0C7);
    close_cs;
    check("R7 last", last, 24'h0C7);

    // R1: start inside the mailbox and leave it
    open_cs;
    rd_range(24'h0B0, 24'h0C3);
    close_cs;

    // R4: passthrough, blocked then forwarded
    pmode = 1'b1; filt = 1'b1;
    open_cs;
    rd_range(24'h09C, 24'h0A3);
    close_cs;
    filt = 1'b0;
    open_cs;
    rd_range(24'h0BC, 24'h0C3);
    close_cs;

    // R2: mailbox disabled, same window reads as buffer
    pmode = 1'b0; men = 1'b0;
    open_cs;
    rd_range(24'h0A0, 24'h0A7);
    close_cs;
    check("R7 last", last, 24'h0A7);

    // R7: empty transaction and bytes with chip select high
    open_cs;
    close_cs;
    check("R7 empty", last, 24'h0A7);
    @(negedge clk); bvld = 1'b1; baddr = 24'h055;
    @(negedge clk); bvld = 1'b0;
    check("R7 ignored flip", AW'(flip), '0);
    @(negedge clk); csb = 1'b0;
    close_cs;
    check("R7 ignored last", last, 24'h0A7);

    // R6: zero threshold, flip and watermark on the same byte
    thr = '0;
    open_cs;
    rd_range(24'h040, 24'h042);
    close_cs;

    check("R5 scoreboard drained", AW'(expq.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule